// File: doc/BRIEF.md
# Cascaded Rotating-Priority Interrupt Controller

This block merges sixteen interrupt request lines into one request toward a processor. Inside it are two identical eight-input controller units. The secondary unit's request output drives input 2 of the primary unit. The primary unit raises `irq_o`, and the processor answers with a one-cycle `ack_i`. In the cycle after the acknowledge, the block presents an 8-bit vector. That vector is a programmable base plus the index of the line that won.

Each unit holds its own base, mask, in-service state and priority origin. Software sets the priority origin in two ways. It can name the lowest-priority line directly. It can also switch on automatic rotation, where each end-of-interrupt moves the line it retires to the bottom. Software drives the unit through a small command port: one valid strobe, a unit select, an opcode and one data byte. The vector values are only labels for the lines. Priority is decided only by each unit's rotation state and by the cascade point.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset the bases are 0x08 (primary) and 0x70 (secondary), all masks are clear, automatic rotation is off, each unit's lowest-priority line is 7, and `irq_o` and `vec_vld_o` are low.
- R2: With reset rotation, the sixteen lines are serviced highest first in the order 0,1,8,9,10,11,12,13,14,15,3,4,5,6,7. Raw line 2 is ignored because the secondary unit occupies that slot.
- R3: Opcode 2 (rotate) loads `cmd_data_i[2:0]` as the selected unit's lowest-priority line. The highest-priority line becomes that value plus 1, modulo 8. For example, lowest 2 on the primary gives the order 3,4,5,6,7,0,1,8..15.
- R4: When opcode 3 has set `cmd_data_i[0]`=1 (automatic rotation), each end-of-interrupt on that unit makes the line it cleared the lowest priority.
- R5: The vector equals the unit's base plus the line index within the unit. Opcode 0 loads the selected unit's base from `cmd_data_i`.
- R6: When the primary winner is input 2, the acknowledge takes its vector from the secondary winner. It also sets in-service bit 2 of the primary and the winner's in-service bit in the secondary.
- R7: A pending request is forwarded only if it has higher priority than every in-service line of its unit.
- R8: Opcode 1 loads the selected unit's mask from `cmd_data_i`. Mask bit n set blocks line n of that unit.
- R9: Opcode 4 (non-specific end-of-interrupt) clears the highest-priority in-service bit of the selected unit.
- R10: An acknowledge with no forwarded request returns the primary base plus the primary's current lowest-priority line, and changes no in-service bit.
- R11: `vec_vld_o` is high for exactly the cycle after each `ack_i` cycle, and `vec_o` holds that acknowledge's vector.
- R12: `irq_o` is high only while the primary unit has an unmasked pending input that it forwards. The unit select is `cmd_sel_i` (0 primary, 1 secondary).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | 16 | Level request lines; bits 15..8 go to the secondary, bit 2 is unused |
| cmd_vld_i | input | 1 | Command strobe, one cycle per command |
| cmd_sel_i | input | 1 | Target unit: 0 primary, 1 secondary |
| cmd_op_i | input | 3 | 0 base, 1 mask, 2 rotate, 3 auto mode, 4 end-of-interrupt |
| cmd_data_i | input | 8 | Command operand |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | Interrupt acknowledge from the processor, one cycle |
| vec_o | output | 8 | Vector of the last acknowledge |
| vec_vld_o | output | 1 | Vector valid, the cycle after `ack_i` |

## Verification
The assertions check the handshake on every cycle: the vector strobe follows each acknowledge and never appears without one, and each vector falls inside one unit's base window. They also check three things on every cycle: a new secondary in-service bit always appears together with a new primary bit 2, `irq_o` never rises without an unmasked pending request, and an unanswered acknowledge leaves the in-service state unchanged. The effective sixteen-line order under every pair of rotation settings can only be shown by the bench's scenarios. The same holds for nesting under in-service lines, automatic rotation across successive end-of-interrupts, masking, and the spurious vector.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned UNIT_LINES = 8;
  localparam int unsigned IDX_W      = $clog2(UNIT_LINES);
  localparam int unsigned VEC_W      = 8;
  localparam int unsigned CASC_LINE  = 2;

  typedef enum logic [2:0] {
    OP_BASE = 3'd0,
    OP_MASK = 3'd1,
    OP_ROT  = 3'd2,
    OP_AUTO = 3'd3,
    OP_EOI  = 3'd4
  } irq_op_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Highest-priority set bit under rotation; rank 0 is highest.
module irq_prio_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] low_i,
  output logic         vld_o,
  output logic [W-1:0] idx_o,
  output logic [W-1:0] rank_o
);
  always_comb begin
    vld_o  = 1'b0;
    idx_o  = '0;
    rank_o = '0;
    for (int r = N - 1; r >= 0; r--) begin
      logic [W-1:0] li;
      li = low_i + W'(r + 1);
      if (req_i[li]) begin
        vld_o  = 1'b1;
        idx_o  = li;
        rank_o = W'(r);
      end
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_pkg::*;
#(
  parameter logic [VEC_W-1:0] BASE_RST = 8'h08
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [UNIT_LINES-1:0] req_i,
  input  logic                  cmd_vld_i,
  input  irq_op_e               cmd_op_i,
  input  logic [VEC_W-1:0]      cmd_data_i,
  input  logic                  ack_i,
  output logic                  int_o,
  output logic [IDX_W-1:0]      win_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic [UNIT_LINES-1:0] isr_o,
  output logic [UNIT_LINES-1:0] pend_o,
  output logic [VEC_W-1:0]      base_o,
  output logic [IDX_W-1:0]      low_o
);
  logic [UNIT_LINES-1:0] mask_q, isr_q, isr_set, isr_clr;
  logic [VEC_W-1:0]      base_q;
  logic [IDX_W-1:0]      low_q;
  logic                  auto_q;

  logic                  p_vld, s_vld;
  logic [IDX_W-1:0]      p_idx, s_idx, p_rank, s_rank;
  logic                  eoi;

  assign pend_o = req_i & ~mask_q;

  irq_prio_pick #(.N(UNIT_LINES)) u_pend_pick (
    .req_i(pend_o), .low_i(low_q), .vld_o(p_vld), .idx_o(p_idx), .rank_o(p_rank)
  );
  irq_prio_pick #(.N(UNIT_LINES)) u_isr_pick (
    .req_i(isr_q), .low_i(low_q), .vld_o(s_vld), .idx_o(s_idx), .rank_o(s_rank)
  );

  assign int_o = p_vld && (!s_vld || (p_rank < s_rank));
  assign win_o = p_idx;
  // Spurious: report current lowest-priority line
  assign vec_o = base_q + VEC_W'(int_o ? p_idx : low_q);

  assign eoi     = cmd_vld_i && (cmd_op_i == OP_EOI) && s_vld;
  assign isr_set = (ack_i && int_o) ? (UNIT_LINES'(1) << p_idx) : '0;
  assign isr_clr = eoi ? (UNIT_LINES'(1) << s_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      isr_q  <= '0;
      base_q <= BASE_RST;
      low_q  <= IDX_W'(UNIT_LINES - 1);
      auto_q <= 1'b0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      if (cmd_vld_i) begin
        unique case (cmd_op_i)
          OP_BASE: base_q <= cmd_data_i;
          OP_MASK: mask_q <= cmd_data_i[UNIT_LINES-1:0];
          OP_ROT:  low_q  <= cmd_data_i[IDX_W-1:0];
          OP_AUTO: auto_q <= cmd_data_i[0];
          OP_EOI:  if (s_vld && auto_q) low_q <= s_idx;
          default: ;
        endcase
      end
    end
  end

  assign isr_o  = isr_q;
  assign base_o = base_q;
  assign low_o  = low_q;
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import irq_pkg::*;
#(
  parameter logic [VEC_W-1:0] PRI_BASE_RST = 8'h08,
  parameter logic [VEC_W-1:0] SEC_BASE_RST = 8'h70,
  localparam int unsigned     TOT_LINES    = 2 * UNIT_LINES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TOT_LINES-1:0] irq_lines_i,
  input  logic                 cmd_vld_i,
  input  logic                 cmd_sel_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [VEC_W-1:0]     cmd_data_i,
  output logic                 irq_o,
  input  logic                 ack_i,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_vld_o
);
  logic [TOT_LINES-1:0]  lines_q;
  logic [UNIT_LINES-1:0] pri_req, pri_isr, sec_isr, pri_pend, sec_pend;
  logic [VEC_W-1:0]      pri_vec, sec_vec, pri_base, sec_base, vec_q;
  logic [IDX_W-1:0]      pri_win, sec_win, pri_low, sec_low;
  logic                  pri_int, sec_int, sec_ack, to_sec, vld_q;
  irq_op_e               op;

  assign op = irq_op_e'(cmd_op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lines_q <= '0;
    else         lines_q <= irq_lines_i;
  end

  always_comb begin
    pri_req            = lines_q[UNIT_LINES-1:0];
    pri_req[CASC_LINE] = sec_int;
  end

  assign to_sec  = pri_int && (pri_win == IDX_W'(CASC_LINE));
  assign sec_ack = ack_i && to_sec;

  irq_unit #(.BASE_RST(PRI_BASE_RST)) u_pri (
    .clk_i, .rst_ni,
    .req_i(pri_req),
    .cmd_vld_i(cmd_vld_i && !cmd_sel_i),
    .cmd_op_i(op), .cmd_data_i,
    .ack_i(ack_i),
    .int_o(pri_int), .win_o(pri_win), .vec_o(pri_vec),
    .isr_o(pri_isr), .pend_o(pri_pend), .base_o(pri_base), .low_o(pri_low)
  );

  irq_unit #(.BASE_RST(SEC_BASE_RST)) u_sec (
    .clk_i, .rst_ni,
    .req_i(lines_q[TOT_LINES-1:UNIT_LINES]),
    .cmd_vld_i(cmd_vld_i && cmd_sel_i),
    .cmd_op_i(op), .cmd_data_i,
    .ack_i(sec_ack),
    .int_o(sec_int), .win_o(sec_win), .vec_o(sec_vec),
    .isr_o(sec_isr), .pend_o(sec_pend), .base_o(sec_base), .low_o(sec_low)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= ack_i;
      if (ack_i) vec_q <= to_sec ? sec_vec : pri_vec;
    end
  end

  assign irq_o     = pri_int;
  assign vec_o     = vec_q;
  assign vec_vld_o = vld_q;
endmodule

// File: rtl/cascade_irq_ctrl_chk.sv
module cascade_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_i,
  input logic       irq_o,
  input logic       vec_vld_o,
  input logic [7:0] vec_o,
  input logic [7:0] pri_isr,
  input logic [7:0] sec_isr,
  input logic [7:0] pri_pend,
  input logic [7:0] pri_base,
  input logic [7:0] sec_base
);
  AST_VLD_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_vld_o); // R11
  AST_VLD_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> $past(ack_i)); // R11
  AST_VEC_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> ((8'(vec_o - $past(pri_base)) < 8'd8) ||
                   (8'(vec_o - $past(sec_base)) < 8'd8))); // R5
  AST_CASCADE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sec_isr & ~$past(sec_isr)) != 8'd0) |-> (pri_isr[2] && !$past(pri_isr[2]))); // R6
  AST_IRQ_HAS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pri_pend != 8'd0)); // R12
  AST_SPURIOUS_NO_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> (pri_isr == $past(pri_isr))); // R10
  AST_ONE_ISR_PER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pri_isr & ~$past(pri_isr)) <= 1); // R7
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .irq_o(irq_o),
  .vec_vld_o(vec_vld_o), .vec_o(vec_o), .pri_isr(pri_isr), .sec_isr(sec_isr),
  .pri_pend(pri_pend), .pri_base(pri_base), .sec_base(sec_base)
);

// File: tb/tb_cascade_irq_ctrl.sv
module tb_cascade_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_lines_i = '0;
  logic        cmd_vld_i = 1'b0, cmd_sel_i = 1'b0;
  logic [2:0]  cmd_op_i = '0;
  logic [7:0]  cmd_data_i = '0;
  logic        irq_o, ack_i = 1'b0, vec_vld_o;
  logic [7:0]  vec_o;
  int checks = 0, failures = 0;
  logic [7:0] pb, sb;

  cascade_irq_ctrl dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0; irq_lines_i = '0;
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic cmd(input logic sel, input logic [2:0] op, input logic [7:0] d);
    @(negedge clk_i); cmd_vld_i = 1'b1; cmd_sel_i = sel; cmd_op_i = op; cmd_data_i = d;
    @(negedge clk_i); cmd_vld_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0;
    v = vec_o;
    chk(vec_vld_o === 1'b1, "R11 vec_vld_o", int'(vec_vld_o), 1);
  endtask

  function automatic int vec2line(input logic [7:0] v);
    if (v >= sb && v < sb + 8) return 8 + int'(v - sb);
    return int'(v - pb);
  endfunction

  initial begin
    #2_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    pb = 8'h08; sb = 8'h70;
    wait_cyc(2);
    chk(irq_o === 1'b0, "R1 irq_o after reset", int'(irq_o), 0);
    chk(vec_vld_o === 1'b0, "R1 vec_vld_o after reset", int'(vec_vld_o), 0);
    rst_ni = 1'b1;

    // R2 / R3 / R6 / R9: order sweep over all rotation pairs
    for (int lp = 0; lp < 8; lp++) begin
      for (int ls = 0; ls < 8; ls++) begin
        int exp_ord[15];
        int k;
        k = 0;
        for (int r = 0; r < 8; r++) begin
          int pl;
          pl = (lp + 1 + r) % 8;
          if (pl == 2) begin
            for (int s = 0; s < 8; s++) begin
              exp_ord[k] = 8 + (ls + 1 + s) % 8; k++;
            end
          end else begin
            exp_ord[k] = pl; k++;
          end
        end
        do_reset();
        cmd(1'b0, 3'd2, 8'(lp));
        cmd(1'b1, 3'd2, 8'(ls));
        irq_lines_i = 16'hFFFB;
        wait_cyc(1);
        for (int j = 0; j < 15; j++) begin
          int ln;
          do_ack(v);
          ln = vec2line(v);
          chk(ln == exp_ord[j],
              (lp == 7 && ls == 7) ? "R2 reset order" : "R3 R6 rotated order",
              ln, exp_ord[j]);
          irq_lines_i[ln] = 1'b0;
          if (ln >= 8) cmd(1'b1, 3'd4, 8'h00);
          cmd(1'b0, 3'd4, 8'h00);
        end
        chk(irq_o === 1'b0, "R9 all retired", int'(irq_o), 0);
      end
    end

    // R5: vector per line, default and programmed bases
    for (int b = 0; b < 2; b++) begin
      do_reset();
      if (b == 1) begin
        cmd(1'b0, 3'd0, 8'h50); cmd(1'b1, 3'd0, 8'h70);
      end
      for (int ln = 0; ln < 16; ln++) begin
        int ev;
        if (ln == 2) continue;
        ev = (ln >= 8) ? (8'h70 + ln - 8) : ((b == 1 ? 8'h50 : 8'h08) + ln);
        irq_lines_i = 16'(1) << ln;
        wait_cyc(1);
        do_ack(v);
        chk(int'(v) == ev, "R5 vector base+index", int'(v), ev);
        irq_lines_i = '0;
        if (ln >= 8) cmd(1'b1, 3'd4, 8'h00);
        cmd(1'b0, 3'd4, 8'h00);
      end
    end
    pb = 8'h08;

    // R7 / R9: nesting under in-service lines
    do_reset();
    irq_lines_i = 16'h0020; wait_cyc(1);
    do_ack(v); chk(v == 8'h0D, "R7 first line 5", int'(v), 8'h0D);
    irq_lines_i[6] = 1'b1; wait_cyc(2);
    chk(irq_o === 1'b0, "R7 lower blocked", int'(irq_o), 0);
    irq_lines_i[3] = 1'b1; wait_cyc(2);
    chk(irq_o === 1'b1, "R7 higher nests", int'(irq_o), 1);
    do_ack(v); chk(v == 8'h0B, "R7 nested line 3", int'(v), 8'h0B);
    irq_lines_i[3] = 1'b0;
    cmd(1'b0, 3'd4, 8'h00); wait_cyc(1);
    chk(irq_o === 1'b0, "R9 EOI cleared 3 not 5", int'(irq_o), 0);
    cmd(1'b0, 3'd4, 8'h00); wait_cyc(1);
    chk(irq_o === 1'b1, "R9 EOI cleared 5", int'(irq_o), 1);
    do_ack(v); chk(v == 8'h0D, "R9 line 5 again", int'(v), 8'h0D);

    // R4: automatic rotation versus none
    do_reset();
    irq_lines_i = 16'h0003; wait_cyc(1);
    do_ack(v); cmd(1'b0, 3'd4, 8'h00);
    do_ack(v); chk(v == 8'h08, "R4 no auto keeps line 0 first", int'(v), 8'h08);
    do_reset();
    cmd(1'b0, 3'd3, 8'h01);
    irq_lines_i = 16'h0003; wait_cyc(1);
    do_ack(v); chk(v == 8'h08, "R4 auto first", int'(v), 8'h08);
    cmd(1'b0, 3'd4, 8'h00);
    do_ack(v); chk(v == 8'h09, "R4 auto rotated to 1", int'(v), 8'h09);
    irq_lines_i = 16'h0001;
    cmd(1'b0, 3'd4, 8'h00);
    do_ack(v); chk(v == 8'h08, "R4 auto line 0 after 1", int'(v), 8'h08);

    // R8 / R10: masking and spurious vector
    do_reset();
    cmd(1'b0, 3'd1, 8'h10);
    irq_lines_i = 16'h0010; wait_cyc(2);
    chk(irq_o === 1'b0, "R8 masked primary line", int'(irq_o), 0);
    do_ack(v); chk(v == 8'h0F, "R10 spurious lowest 7", int'(v), 8'h0F);
    cmd(1'b0, 3'd1, 8'h00); wait_cyc(1);
    chk(irq_o === 1'b1, "R8 unmasked", int'(irq_o), 1);
    do_ack(v); chk(v == 8'h0C, "R8 R10 no isr from spurious", int'(v), 8'h0C);
    do_reset();
    cmd(1'b1, 3'd1, 8'h02);
    irq_lines_i = 16'h0200; wait_cyc(2);
    chk(irq_o === 1'b0, "R8 masked secondary line", int'(irq_o), 0);
    do_reset();
    irq_lines_i = 16'h0040; wait_cyc(1);
    irq_lines_i = '0; wait_cyc(2);
    chk(irq_o === 1'b0, "R12 request withdrawn", int'(irq_o), 0);
    cmd(1'b0, 3'd2, 8'h04);
    do_ack(v); chk(v == 8'h0C, "R10 spurious after rotate", int'(v), 8'h0C);
    wait_cyc(1);
    chk(vec_vld_o === 1'b0, "R11 single-cycle strobe", int'(vec_vld_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule